// File: doc/BRIEF.md
# B-Channel Source Selector and TDM Highway Router

This block sits between three B-channel carriers: the line side, the subscriber bus and a local serial TDM highway that feeds analog-phone codecs. For each of the two upstream B channels it picks, on its own, whether the byte sent toward the line comes from the subscriber bus or from the TDM highway. It also decides whether each downstream B channel from the line is driven onto the TDM highway, and it gates the highway bit clock and frame strobe.

The highway frame is `FRAME_BITS` bit periods long and each bit period is `BIT_DIV` system clocks. The two B channels occupy fixed `SLOT_W`-bit time slots whose start positions are parameters. Two configuration words are written through a write-only control port. The source-select word uses bits 1:0 for B1 and bits 3:2 for B2. The routing word holds active-low slot enables in bits 7:2. A change of source takes effect only at a frame boundary, so no byte is assembled from two sources. The data pin is expressed as data plus output enable, and the pad cell outside the block does the tri-stating.

Top module: `bch_tdm_router`

## Requirements
- R1: After reset, both upstream channels take the subscriber bus, `up_valid`, `tdm_clk`, `tdm_fs` and `tdm_oe` are 0, and `tdm_dat` is 1.
- R2: The upstream B1 byte is `bus_b1` when source-select bits 1:0 are both 1. Any other value of that pair gives the byte captured from `tdm_di` in slot 1, taken MSB first at clock `BIT_DIV/2` of each bit period.
- R3: The upstream B2 byte follows the same rule as B1, from source-select bits 3:2 and slot 2, independently of B1.
- R4: The source selection used for a frame is the word held at the end of the previous frame. A write in the middle of a frame first changes the bytes reported at the end of the following frame.
- R5: `up_valid` is a one-cycle pulse once per frame (`BIT_DIV*FRAME_BITS` clocks). It first appears `BIT_DIV*FRAME_BITS` clocks after reset. The upstream bytes change only with it.
- R6: While `hwy_en_n`=0 and routing bit 5 = 0, slot 1 drives `tdm_oe`=1 and puts out, MSB first, the `line_b1` value sampled at the end of the previous frame.
- R7: While `hwy_en_n`=0 and routing bit 6 = 0, slot 2 drives `tdm_oe`=1 and puts out `line_b2` in the same way, independently of slot 1.
- R8: Outside an enabled slot, `tdm_oe`=0 and `tdm_dat`=1, so the pin reads as all ones.
- R9: `tdm_clk` and `tdm_fs` stay 0 unless `hwy_en_n`=0 and at least one of routing bits 7:2 is 0. When active, `tdm_clk` is 1 for the first `BIT_DIV/2` clocks of each bit period and `tdm_fs` is 1 throughout bit 0 of the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 1 | 0 = source-select word, 1 = routing word |
| cfg_wdata | input | 8 | Configuration write data |
| hwy_en_n | input | 1 | Active-low global TDM highway enable |
| bus_b1 | input | SLOT_W | Upstream B1 byte from subscriber bus |
| bus_b2 | input | SLOT_W | Upstream B2 byte from subscriber bus |
| tdm_di | input | 1 | Serial highway data in |
| line_b1 | input | SLOT_W | Downstream B1 byte from line side |
| line_b2 | input | SLOT_W | Downstream B2 byte from line side |
| up_b1 | output | SLOT_W | Upstream B1 byte toward line side |
| up_b2 | output | SLOT_W | Upstream B2 byte toward line side |
| up_valid | output | 1 | Frame-end pulse marking new upstream bytes |
| tdm_clk | output | 1 | Gated highway bit clock |
| tdm_fs | output | 1 | Gated highway frame strobe |
| tdm_dat | output | 1 | Highway data out (1 when not driven) |
| tdm_oe | output | 1 | Output enable for the highway data pad |

## Verification
The hardest case to reach is a source-select write that lands mid-frame. The old selection must still govern the frame in flight while the new one governs the next. The bench aligns itself to `up_valid`, steps a fixed number of clocks into the frame, writes, and then compares two successive frame reports with bus and highway bytes chosen to differ. The routing sweep covers all 64 slot-enable patterns under both global enable levels. In each frame the bench checks every clock of the output enable, data, bit clock and strobe against the positions computed from the cycle count.

// File: rtl/bch_pkg.sv
// Package: shared address codes and helpers for the B-channel TDM router.
// Assumes: two B channels, configuration words 8 bits wide.
package bch_pkg;
    typedef enum logic {
        CFG_SRC   = 1'b0,
        CFG_ROUTE = 1'b1
    } cfg_addr_e;

    // A channel keeps the subscriber bus only when both of its select bits are 1.
    function automatic logic pick_bus(input logic [1:0] sel_pair);
        return &sel_pair;
    endfunction
endpackage

// File: rtl/bch_frame_timer.sv
// Module: bch_frame_timer
// Counts system clocks into bit periods and bit periods into frames.
// Assumes: BIT_DIV is even and at least 2; counters restart at reset.
module bch_frame_timer #(
    parameter int BIT_DIV    = 4,
    parameter int FRAME_BITS = 32,
    localparam int PW = (BIT_DIV > 1) ? $clog2(BIT_DIV) : 1,
    localparam int BW = $clog2(FRAME_BITS)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [PW-1:0] phase,
    output logic [BW-1:0] bit_idx,
    output logic          mid_bit,
    output logic          bit_end,
    output logic          frame_end
);
    localparam logic [PW-1:0] PH_LAST = PW'(BIT_DIV - 1);
    localparam logic [PW-1:0] PH_MID  = PW'(BIT_DIV / 2);
    localparam logic [BW-1:0] BIT_LAST = BW'(FRAME_BITS - 1);

    assign bit_end   = (phase == PH_LAST);
    assign mid_bit   = (phase == PH_MID);
    assign frame_end = bit_end && (bit_idx == BIT_LAST);

    // Advance clock phase within a bit and bit index within a frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= '0;
            bit_idx <= '0;
        end else if (bit_end) begin
            phase   <= '0;
            bit_idx <= (bit_idx == BIT_LAST) ? '0 : bit_idx + 1'b1;
        end else begin
            phase <= phase + 1'b1;
        end
    end
endmodule

// File: rtl/bch_cfg_regs.sv
// Module: bch_cfg_regs
// Holds the source-select nibble and the active-low routing bits 7:2.
// Assumes: write-only port; unused bits of each word are not stored.
module bch_cfg_regs
    import bch_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic       cfg_addr,
    input  logic [7:0] cfg_wdata,
    output logic [3:0] src_sel,
    output logic [5:0] route_n
);
    // Capture configuration writes; reset selects the bus and disables all slots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_sel <= 4'hF;
            route_n <= 6'h3F;
        end else if (cfg_we) begin
            if (cfg_addr == CFG_SRC) src_sel <= cfg_wdata[3:0];
            else                     route_n <= cfg_wdata[7:2];
        end
    end
endmodule

// File: rtl/bch_up_path.sv
// Module: bch_up_path
// Captures highway slot bytes and chooses, per channel, bus or highway byte
// for the upstream direction, switching source only at frame end.
// Assumes: slots lie wholly inside the frame.
module bch_up_path
    import bch_pkg::*;
#(
    parameter int FRAME_BITS = 32,
    parameter int SLOT_W     = 8,
    parameter int S1_POS     = 1,
    parameter int S2_POS     = 9,
    localparam int BW = $clog2(FRAME_BITS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [BW-1:0]              bit_idx,
    input  logic                       mid_bit,
    input  logic                       frame_end,
    input  logic                       tdm_di,
    input  logic [3:0]                 src_sel,
    input  logic [1:0][SLOT_W-1:0]     bus_b,
    output logic [1:0][SLOT_W-1:0]     up_b,
    output logic                       up_valid
);
    logic [3:0] sel_act;

    // Latch the selection word at the frame boundary only.
    always_ff @(posedge clk) begin
        if (!rst_n)         sel_act <= 4'hF;
        else if (frame_end) sel_act <= src_sel;
    end

    // Frame-end strobe toward the line side.
    always_ff @(posedge clk) begin
        if (!rst_n) up_valid <= 1'b0;
        else        up_valid <= frame_end;
    end

    for (genvar ch = 0; ch < 2; ch++) begin : g_ch
        localparam logic [BW-1:0] LO = BW'((ch == 0) ? S1_POS : S2_POS);
        localparam logic [BW-1:0] HI = BW'(((ch == 0) ? S1_POS : S2_POS) + SLOT_W - 1);
        logic [SLOT_W-1:0] cap;
        logic              in_slot;
        assign in_slot = (bit_idx >= LO) && (bit_idx <= HI);

        // Shift highway bits in, MSB first, at mid-bit within the slot.
        always_ff @(posedge clk) begin
            if (!rst_n)                  cap <= '1;
            else if (mid_bit && in_slot) cap <= {cap[SLOT_W-2:0], tdm_di};
        end

        // Deliver the chosen byte at frame end.
        always_ff @(posedge clk) begin
            if (!rst_n)         up_b[ch] <= '0;
            else if (frame_end) up_b[ch] <= pick_bus(sel_act[2*ch +: 2]) ? bus_b[ch] : cap;
        end
    end

    assert_sel_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> $stable(sel_act));
    assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        up_valid |=> !up_valid);
endmodule

// File: rtl/bch_dn_path.sv
// Module: bch_dn_path
// Serialises the downstream line bytes into their highway slots when enabled.
// Assumes: bytes are taken at frame end and sent in the following frame.
module bch_dn_path #(
    parameter int FRAME_BITS = 32,
    parameter int SLOT_W     = 8,
    parameter int S1_POS     = 1,
    parameter int S2_POS     = 9,
    localparam int BW = $clog2(FRAME_BITS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [BW-1:0]          bit_idx,
    input  logic                   bit_end,
    input  logic                   frame_end,
    input  logic                   hwy_en_n,
    input  logic [1:0]             slot_en_n,
    input  logic [1:0][SLOT_W-1:0] line_b,
    output logic                   tdm_dat,
    output logic                   tdm_oe
);
    logic [1:0] drive;
    logic [1:0] bit_out;

    for (genvar ch = 0; ch < 2; ch++) begin : g_ch
        localparam logic [BW-1:0] LO = BW'((ch == 0) ? S1_POS : S2_POS);
        localparam logic [BW-1:0] HI = BW'(((ch == 0) ? S1_POS : S2_POS) + SLOT_W - 1);
        logic [SLOT_W-1:0] sh;
        logic              in_slot;
        assign in_slot     = (bit_idx >= LO) && (bit_idx <= HI);
        assign drive[ch]   = in_slot && !hwy_en_n && !slot_en_n[ch];
        assign bit_out[ch] = sh[SLOT_W-1];

        // Load at frame end, shift out MSB first at each slot bit end.
        always_ff @(posedge clk) begin
            if (!rst_n)                  sh <= '1;
            else if (frame_end)          sh <= line_b[ch];
            else if (bit_end && in_slot) sh <= {sh[SLOT_W-2:0], 1'b1};
        end
    end

    assign tdm_oe  = |drive;
    assign tdm_dat = drive[0] ? bit_out[0] : (drive[1] ? bit_out[1] : 1'b1);

    assert_idle_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !tdm_oe |-> tdm_dat);
endmodule

// File: rtl/bch_tdm_router.sv
// Module: bch_tdm_router (top)
// Routes two B channels among line side, subscriber bus and a TDM highway;
// gates the highway clock and strobe on the global and slot enables.
// Assumes: BIT_DIV even >= 2; slots start at bit 1 or later and fit the frame.
module bch_tdm_router #(
    parameter int BIT_DIV    = 4,
    parameter int FRAME_BITS = 32,
    parameter int SLOT_W     = 8,
    parameter int S1_POS     = 1,
    parameter int S2_POS     = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_addr,
    input  logic [7:0]        cfg_wdata,
    input  logic              hwy_en_n,
    input  logic [SLOT_W-1:0] bus_b1,
    input  logic [SLOT_W-1:0] bus_b2,
    input  logic              tdm_di,
    input  logic [SLOT_W-1:0] line_b1,
    input  logic [SLOT_W-1:0] line_b2,
    output logic [SLOT_W-1:0] up_b1,
    output logic [SLOT_W-1:0] up_b2,
    output logic              up_valid,
    output logic              tdm_clk,
    output logic              tdm_fs,
    output logic              tdm_dat,
    output logic              tdm_oe
);
    localparam int PW = (BIT_DIV > 1) ? $clog2(BIT_DIV) : 1;
    localparam int BW = $clog2(FRAME_BITS);
    localparam logic [PW-1:0] HALF = PW'(BIT_DIV / 2);

    logic [PW-1:0]          phase;
    logic [BW-1:0]          bit_idx;
    logic                   mid_bit, bit_end, frame_end;
    logic [3:0]             src_sel;
    logic [5:0]             route_n;
    logic [1:0][SLOT_W-1:0] up_b;
    logic                   clk_on;

    bch_frame_timer #(.BIT_DIV(BIT_DIV), .FRAME_BITS(FRAME_BITS)) u_timer (
        .clk(clk), .rst_n(rst_n), .phase(phase), .bit_idx(bit_idx),
        .mid_bit(mid_bit), .bit_end(bit_end), .frame_end(frame_end));

    bch_cfg_regs u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .src_sel(src_sel), .route_n(route_n));

    bch_up_path #(.FRAME_BITS(FRAME_BITS), .SLOT_W(SLOT_W),
                  .S1_POS(S1_POS), .S2_POS(S2_POS)) u_up (
        .clk(clk), .rst_n(rst_n), .bit_idx(bit_idx), .mid_bit(mid_bit),
        .frame_end(frame_end), .tdm_di(tdm_di), .src_sel(src_sel),
        .bus_b({bus_b2, bus_b1}), .up_b(up_b), .up_valid(up_valid));

    // Routing bits 5 and 6 sit at positions 3 and 4 of the stored 7:2 field.
    bch_dn_path #(.FRAME_BITS(FRAME_BITS), .SLOT_W(SLOT_W),
                  .S1_POS(S1_POS), .S2_POS(S2_POS)) u_dn (
        .clk(clk), .rst_n(rst_n), .bit_idx(bit_idx), .bit_end(bit_end),
        .frame_end(frame_end), .hwy_en_n(hwy_en_n),
        .slot_en_n(route_n[4:3]), .line_b({line_b2, line_b1}),
        .tdm_dat(tdm_dat), .tdm_oe(tdm_oe));

    assign up_b1 = up_b[0];
    assign up_b2 = up_b[1];

    // Highway timing runs only with the global enable and any slot enable set.
    assign clk_on  = !hwy_en_n && (route_n != 6'h3F);
    assign tdm_clk = clk_on && (phase < HALF);
    assign tdm_fs  = clk_on && (bit_idx == '0);

    assert_oe_clear_of_fs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tdm_oe |-> !tdm_fs);
    assert_bytes_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !up_valid |-> $stable(up_b1) && $stable(up_b2));
endmodule

// File: tb/bch_tdm_router_bench.sv
module bch_tdm_router_bench;
    localparam int DIV = 4;
    localparam int FB  = 32;
    localparam int S1  = 1;
    localparam int S2  = 9;
    localparam int FR  = DIV * FB;

    logic clk, rst_n, cfg_we, cfg_addr, hwy_en_n, tdm_di;
    logic [7:0] cfg_wdata, bus_b1, bus_b2, line_b1, line_b2, up_b1, up_b2;
    logic up_valid, tdm_clk, tdm_fs, tdm_dat, tdm_oe;
    logic [7:0] t1, t2;
    int c, checks, errors;
    bit done;

    bch_tdm_router #(.BIT_DIV(DIV), .FRAME_BITS(FB), .SLOT_W(8),
                     .S1_POS(S1), .S2_POS(S2)) u_bch_tdm_router (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .hwy_en_n(hwy_en_n), .bus_b1(bus_b1),
        .bus_b2(bus_b2), .tdm_di(tdm_di), .line_b1(line_b1), .line_b2(line_b2),
        .up_b1(up_b1), .up_b2(up_b2), .up_valid(up_valid), .tdm_clk(tdm_clk),
        .tdm_fs(tdm_fs), .tdm_dat(tdm_dat), .tdm_oe(tdm_oe));

    initial begin clk = 1'b0; forever #4 clk = ~clk; end

    // Cycle index since reset release: state c has phase c%DIV, bit (c/DIV)%FB.
    always @(posedge clk) begin
        if (!rst_n) c <= 0;
        else        c <= c + 1;
    end

    // Highway input model: slot bytes MSB first, 1 elsewhere.
    always @(negedge clk) begin
        int b;
        b = (c % FR) / DIV;
        if (b >= S1 && b < S1 + 8)      tdm_di = t1[7 - (b - S1)];
        else if (b >= S2 && b < S2 + 8) tdm_di = t2[7 - (b - S2)];
        else                            tdm_di = 1'b1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h (cycle %0d)", req, act, exp, c);
        end
    endtask

    task automatic cfg_write(input logic a, input logic [7:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_valid();
        do @(negedge clk); while (!up_valid);
    endtask

    function automatic logic [7:0] pick(input logic [1:0] s, input logic [7:0] b, input logic [7:0] t);
        return (s == 2'b11) ? b : t;
    endfunction

    initial begin
        checks = 0; errors = 0; done = 0;
        rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = 1'b0; cfg_wdata = '0;
        hwy_en_n = 1'b1; bus_b1 = 8'h11; bus_b2 = 8'h22; line_b1 = 8'hFF; line_b2 = 8'hFF;
        t1 = 8'hA5; t2 = 8'h3C;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 up_valid", up_valid, 0);
        chk("R1 tdm_oe", tdm_oe, 0);
        chk("R1 tdm_dat", tdm_dat, 1);
        chk("R1 tdm_clk", tdm_clk, 0);
        chk("R1 tdm_fs", tdm_fs, 0);
        // R5: first pulse exactly one frame after reset
        wait_valid();
        chk("R5 first pulse cycle", c, FR);
        chk("R1 default bus B1", up_b1, 8'h11);
        chk("R1 default bus B2", up_b2, 8'h22);
        @(negedge clk);
        chk("R5 one-cycle pulse", up_valid, 0);
        wait_valid();
        chk("R5 period", c, 2 * FR);

        // R2 R3: every source-select nibble
        for (int n = 0; n < 16; n++) begin
            cfg_write(1'b0, {4'hF, n[3:0]});
            bus_b1 = 8'(n * 17 + 3);  bus_b2 = 8'(~(n * 29));
            t1 = 8'(n * 53 + 90);     t2 = 8'(n * 11 + 195);
            wait_valid();
            wait_valid();
            chk("R2 B1 source", up_b1, pick(n[1:0], bus_b1, t1));
            chk("R3 B2 source", up_b2, pick(n[3:2], bus_b2, t2));
        end

        // R4: mid-frame write only affects the frame after the current one
        cfg_write(1'b0, 8'hFF);
        bus_b1 = 8'h5A; bus_b2 = 8'h69; t1 = 8'hC3; t2 = 8'h0F;
        wait_valid();
        wait_valid();
        repeat (60) @(negedge clk);
        cfg_write(1'b0, 8'hF0);
        wait_valid();
        chk("R4 old B1 kept", up_b1, 8'h5A);
        chk("R4 old B2 kept", up_b2, 8'h69);
        wait_valid();
        chk("R4 new B1", up_b1, 8'hC3);
        chk("R4 new B2", up_b2, 8'h0F);

        // R6 R7 R8 R9: every routing pattern under both global enable levels
        begin
            logic [7:0] prev1, prev2;
            prev1 = line_b1; prev2 = line_b2;
            for (int n = 0; n < 128; n++) begin
                logic on, hw;
                logic [5:0] rn;
                rn = n[5:0]; hw = n[6];
                hwy_en_n = hw;
                line_b1 = 8'(n * 37 + 5); line_b2 = 8'(n * 91 + 200);
                cfg_write(1'b1, {rn, 2'b11});
                on = !hw && (rn != 6'h3F);
                for (int k = 1; k < FR; k++) begin
                    int b, ph;
                    logic e_oe, e_dat;
                    b = k / DIV; ph = k % DIV;
                    chk("R9 tdm_clk", tdm_clk, on && (ph < DIV / 2));
                    chk("R9 tdm_fs", tdm_fs, on && (b == 0));
                    if (b >= S1 && b < S1 + 8) begin
                        e_oe = !hw && !rn[3];
                        e_dat = e_oe ? prev1[7 - (b - S1)] : 1'b1;
                        chk("R6 slot1 oe", tdm_oe, e_oe);
                        chk("R6 slot1 dat", tdm_dat, e_dat);
                    end else if (b >= S2 && b < S2 + 8) begin
                        e_oe = !hw && !rn[4];
                        e_dat = e_oe ? prev2[7 - (b - S2)] : 1'b1;
                        chk("R7 slot2 oe", tdm_oe, e_oe);
                        chk("R7 slot2 dat", tdm_dat, e_dat);
                    end else begin
                        chk("R8 idle oe", tdm_oe, 0);
                        chk("R8 idle dat", tdm_dat, 1);
                    end
                    @(negedge clk);
                end
                prev1 = line_b1; prev2 = line_b2;
            end
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule